// File: doc/BRIEF.md
# Sample-Hold and Multiplexer Command Arbiter

This block drives the hold/release control of one amplifier's sample-and-hold stage and the channel select of the ADC front-end multiplexer. Two sources can set these two controls. In manual mode a software-written configuration byte sets them. In automatic mode 8-bit command bytes set them. A sequencing engine issues those bytes and delivers them through an event multiplexer. Both sources use the same bit layout: bit 0 is the hold bit and bits 3:1 are the channel number.

A small control register holds three bits. The first enables the event-multiplexer command path. The second enables the ADC buffer. The third chooses whether the multiplexer sees the held output or bypasses the sample-and-hold. Clearing the command-path enable returns the automatic state to release and channel 0, and it stays there until the enable is set again. The block also qualifies ADC sample requests. A request made while the buffer is disabled is blocked and an error pulse is raised in its place.

Top module: `shm_arbiter`

## Requirements
- R1: After reset, holdOut=0, chanOut=0, pathSel=0, adcReady=0, smpGo=0 and smpErr=0, and both the manual and automatic states are release/channel 0.
- R2: With autoMode=0, a manWr cycle stores manData. From the next cycle holdOut equals manData[0] and chanOut equals manData[3:1]. manData[7:4] has no effect.
- R3: With autoMode=1 and the command path enabled, a cmdValid cycle stores cmdByte using the same layout as R2 (bit 0 is hold, bits 3:1 are the channel). The result appears on holdOut/chanOut from the next cycle.
- R4: In automatic mode, a cycle with cmdValid=0 leaves holdOut and chanOut unchanged, whatever cmdByte carries.
- R5: A ctlWr with ctlData[0]=0 clears the automatic state to release/channel 0 at that same clock edge. While the enable is 0, cmdValid has no effect.
- R6: The manual and automatic states are independent. autoMode selects which one drives the outputs, combinationally. A manual write made during automatic mode appears only once autoMode returns to 0.
- R7: pathSel equals ctlData[2] from the last ctlWr. A value of 1 routes the held output to the multiplexer and 0 bypasses the sample-and-hold.
- R8: adcReady equals the buffer-enable bit ctlData[1] from the last ctlWr.
- R9: A smpReq while adcReady=1 gives a one-cycle smpGo=1 and smpErr=0 on the next cycle.
- R10: A smpReq while adcReady=0 is blocked and gives smpErr=1 and smpGo=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWr | input | 1 | Control register write strobe |
| ctlData | input | 3 | Control bits: [0] command-path enable, [1] buffer enable, [2] route through sample-and-hold |
| manWr | input | 1 | Manual configuration write strobe |
| manData | input | 8 | Manual configuration byte: [0] hold, [3:1] channel |
| autoMode | input | 1 | 1 when the sequencing engine owns the controls |
| cmdValid | input | 1 | Command byte valid strobe |
| cmdByte | input | 8 | Command byte, same layout as manData |
| smpReq | input | 1 | ADC sample request |
| holdOut | output | 1 | 1 = hold, 0 = release |
| chanOut | output | 3 | Front-end multiplexer channel |
| pathSel | output | 1 | 1 = held output to multiplexer, 0 = bypass |
| adcReady | output | 1 | Buffer enabled, sampling allowed |
| smpGo | output | 1 | Accepted sample pulse |
| smpErr | output | 1 | Blocked sample error pulse |

## Verification
The bench targets an enable clear that arrives in the same cycle as a valid command. A design that lets the command win would leave a stale hold asserted after the path was disabled. It also checks manual writes made during automatic mode: a design sharing one state register would change the channel under the engine's feet, or lose the software setting when control returns. Sample requests are issued with the buffer off and then on. A design that lets a request through unbuffered would raise smpGo where only smpErr may rise. Command bytes with junk in bits 7:4 catch a decoder that reads the wrong field.

// File: rtl/shm_pkg.sv
package shm_pkg;
  localparam int CMD_W    = 8;
  localparam int CHAN_W   = 3;
  localparam int HOLD_BIT = 0;
  localparam int CHAN_LSB = 1;
  localparam int CTL_W    = 3;
  localparam int CTL_MUX  = 0;
  localparam int CTL_BUF  = 1;
  localparam int CTL_ROUTE = 2;

  typedef struct packed {
    logic manLoad;
    logic cmdLoad;
    logic cmdClear;
    logic smpGo;
    logic smpErr;
  } shmStrobe_t;
endpackage

// File: rtl/shm_ctrl.sv
module shm_ctrl
  import shm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [CTL_W-1:0] ctlData,
  input  logic             manWr,
  input  logic             cmdValid,
  input  logic             smpReq,
  output shmStrobe_t       strb,
  output logic             bufEn,
  output logic             route
);
  logic [CTL_W-1:0] ctlQ;
  logic             muxNext;

  always_ff @(posedge clk) begin
    if (!rstN)      ctlQ <= '0;
    else if (ctlWr) ctlQ <= ctlData;
  end

  // The enable that will hold after this edge decides clear versus load,
  // so a clear issued together with a command always wins.
  assign muxNext = ctlWr ? ctlData[CTL_MUX] : ctlQ[CTL_MUX];

  always_comb begin
    strb.manLoad  = manWr;
    strb.cmdClear = !muxNext;
    strb.cmdLoad  = cmdValid && muxNext;
    strb.smpGo    = smpReq && ctlQ[CTL_BUF];
    strb.smpErr   = smpReq && !ctlQ[CTL_BUF];
  end

  assign bufEn = ctlQ[CTL_BUF];
  assign route = ctlQ[CTL_ROUTE];
endmodule

// File: rtl/shm_datapath.sv
module shm_datapath
  import shm_pkg::*;
#(
  parameter int DW = CMD_W,
  parameter int CW = CHAN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  shmStrobe_t    strb,
  input  logic [DW-1:0] manData,
  input  logic [DW-1:0] cmdByte,
  input  logic          autoMode,
  output logic          holdOut,
  output logic [CW-1:0] chanOut,
  output logic          smpGo,
  output logic          smpErr
);
  localparam int CHAN_MSB = CHAN_LSB + CW - 1;

  logic          manHold, autoHold;
  logic [CW-1:0] manChan, autoChan;
  logic          unusedHi;

  assign unusedHi = ^{manData[DW-1:CHAN_MSB+1], cmdByte[DW-1:CHAN_MSB+1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      manHold <= 1'b0;
      manChan <= '0;
    end else if (strb.manLoad) begin
      manHold <= manData[HOLD_BIT];
      manChan <= manData[CHAN_MSB:CHAN_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.cmdClear) begin
      autoHold <= 1'b0;
      autoChan <= '0;
    end else if (strb.cmdLoad) begin
      autoHold <= cmdByte[HOLD_BIT];
      autoChan <= cmdByte[CHAN_MSB:CHAN_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smpGo  <= 1'b0;
      smpErr <= 1'b0;
    end else begin
      smpGo  <= strb.smpGo;
      smpErr <= strb.smpErr;
    end
  end

  assign holdOut = autoMode ? autoHold : manHold;
  assign chanOut = autoMode ? autoChan : manChan;
endmodule

// File: rtl/shm_arbiter.sv
module shm_arbiter
  import shm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWr,
  input  logic [CTL_W-1:0]  ctlData,
  input  logic              manWr,
  input  logic [CMD_W-1:0]  manData,
  input  logic              autoMode,
  input  logic              cmdValid,
  input  logic [CMD_W-1:0]  cmdByte,
  input  logic              smpReq,
  output logic              holdOut,
  output logic [CHAN_W-1:0] chanOut,
  output logic              pathSel,
  output logic              adcReady,
  output logic              smpGo,
  output logic              smpErr
);
  shmStrobe_t strb;

  shm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlData(ctlData),
    .manWr(manWr), .cmdValid(cmdValid), .smpReq(smpReq),
    .strb(strb), .bufEn(adcReady), .route(pathSel)
  );

  shm_datapath #(.DW(CMD_W), .CW(CHAN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .manData(manData),
    .cmdByte(cmdByte), .autoMode(autoMode), .holdOut(holdOut),
    .chanOut(chanOut), .smpGo(smpGo), .smpErr(smpErr)
  );
endmodule

// File: rtl/shm_arbiter_chk.sv
module shm_arbiter_chk
  import shm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ctlWr,
  input logic [CTL_W-1:0]  ctlData,
  input logic              manWr,
  input logic [CMD_W-1:0]  manData,
  input logic              autoMode,
  input logic              cmdValid,
  input logic              smpReq,
  input logic              holdOut,
  input logic [CHAN_W-1:0] chanOut,
  input logic              pathSel,
  input logic              adcReady,
  input logic              smpGo,
  input logic              smpErr
);
  a_r9_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(smpGo && smpErr));

  a_r9_accept: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && adcReady) |=> (smpGo && !smpErr));

  a_r10_block: assert property (@(posedge clk) disable iff (!rstN)
    (smpReq && !adcReady) |=> (smpErr && !smpGo));

  a_r7_route: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> (pathSel == $past(ctlData[CTL_ROUTE])));

  a_r8_buffer: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> (adcReady == $past(ctlData[CTL_BUF])));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !ctlData[CTL_MUX]) |=> (!autoMode || (!holdOut && chanOut == '0)));

  a_r4_keep: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && !cmdValid && !ctlWr) |=>
      (!autoMode || ($stable(holdOut) && $stable(chanOut))));

  a_r2_manual: assert property (@(posedge clk) disable iff (!rstN)
    (!autoMode && manWr) |=>
      (autoMode || (holdOut == $past(manData[HOLD_BIT]) &&
                    chanOut == $past(manData[CHAN_LSB+CHAN_W-1:CHAN_LSB]))));
endmodule

bind shm_arbiter shm_arbiter_chk chk_i (.*);

// File: tb/shm_arbiter_tb_top.sv
module shm_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWr = 0, manWr = 0, autoMode = 0, cmdValid = 0, smpReq = 0;
  logic [2:0] ctlData = '0;
  logic [7:0] manData = '0, cmdByte = '0;
  logic       holdOut, pathSel, adcReady, smpGo, smpErr;
  logic [2:0] chanOut;

  int nChk = 0, nErr = 0;
  logic       mHold = 0, aHold = 0, mux = 0, buff = 0, route = 0, eGo = 0, eErr = 0;
  logic [2:0] mChan = 0, aChan = 0;

  always #5 clk = ~clk;

  shm_arbiter dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic fHold(input logic [7:0] b); return b[0]; endfunction
  function automatic logic [2:0] fChan(input logic [7:0] b); return b[3:1]; endfunction

  task automatic checkAll();
    if (autoMode) begin
      chk("R3 hold", holdOut, aHold); chk("R3 chan", chanOut, aChan);
    end else begin
      chk("R2 hold", holdOut, mHold); chk("R2 chan", chanOut, mChan);
    end
    chk("R7 pathSel", pathSel, route);
    chk("R8 adcReady", adcReady, buff);
    chk("R9 smpGo", smpGo, eGo);
    chk("R10 smpErr", smpErr, eErr);
  endtask

  // drive inputs (already set), clock once, update model, check
  task automatic step();
    logic effMux;
    @(posedge clk);
    eGo = smpReq & buff;
    eErr = smpReq & ~buff;
    if (manWr) begin mHold = fHold(manData); mChan = fChan(manData); end
    effMux = ctlWr ? ctlData[0] : mux;
    if (ctlWr) begin mux = ctlData[0]; buff = ctlData[1]; route = ctlData[2]; end
    if (!effMux) begin aHold = 0; aChan = 0; end
    else if (cmdValid) begin aHold = fHold(cmdByte); aChan = fChan(cmdByte); end
    #1;
    checkAll();
    ctlWr = 0; manWr = 0; cmdValid = 0; smpReq = 0;
  endtask

  initial begin
    #(10 * 200000);
    nErr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 hold", holdOut, 0); chk("R1 chan", chanOut, 0);
    chk("R1 pathSel", pathSel, 0); chk("R1 adcReady", adcReady, 0);
    chk("R1 smpGo", smpGo, 0); chk("R1 smpErr", smpErr, 0);
    rstN = 1;
    autoMode = 1; step();
    chk("R1 auto state", {holdOut, chanOut}, 0);

    // R7 R8: enable everything
    ctlWr = 1; ctlData = 3'b111; step();
    chk("R7 route on", pathSel, 1); chk("R8 buffer on", adcReady, 1);

    // R3: command with junk high nibble
    autoMode = 1; cmdValid = 1; cmdByte = 8'hF7; step();
    chk("R3 cmd hold", holdOut, 1); chk("R3 cmd chan", chanOut, 3);

    // R4: no strobe, different byte
    cmdByte = 8'h00; step();
    chk("R4 hold kept", holdOut, 1); chk("R4 chan kept", chanOut, 3);

    // R6: manual write during auto mode is invisible
    manWr = 1; manData = 8'hAC; step();
    chk("R6 auto unchanged", chanOut, 3);
    autoMode = 0; #1;
    chk("R6 manual hold", holdOut, 0); chk("R6 manual chan", chanOut, 6);
    autoMode = 1; #1;

    // R5: clear together with a command; clear wins
    ctlWr = 1; ctlData = 3'b110; cmdValid = 1; cmdByte = 8'h0F; step();
    chk("R5 cleared hold", holdOut, 0); chk("R5 cleared chan", chanOut, 0);
    cmdValid = 1; cmdByte = 8'h05; step();
    chk("R5 ignored cmd", {holdOut, chanOut}, 0);

    // R10 then R9
    ctlWr = 1; ctlData = 3'b000; step();
    smpReq = 1; step();
    chk("R10 blocked err", smpErr, 1); chk("R10 blocked go", smpGo, 0);
    ctlWr = 1; ctlData = 3'b011; step();
    smpReq = 1; step();
    chk("R9 accepted go", smpGo, 1); chk("R9 accepted err", smpErr, 0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      autoMode = ($urandom % 4) != 0;
      ctlWr    = ($urandom % 10) == 0;
      ctlData  = 3'($urandom % 8);
      if (($urandom % 3) != 0) ctlData[0] = 1'b1;
      manWr    = ($urandom % 4) == 0;
      manData  = 8'($urandom);
      cmdValid = ($urandom % 3) == 0;
      cmdByte  = 8'($urandom);
      smpReq   = ($urandom % 4) == 0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule